// File: doc/BRIEF.md
# Coherence Message History Predictor

This block guesses which coherence message will next arrive for a given cache block. It sits beside a cache controller or a directory controller. Every message that the controller receives is reported on the update port as a block address, a sender processor number and a 4-bit message kind. The block keeps a short history of recent messages for each tracked block. It also keeps a small pattern table per block that maps a history to the successor that followed it last time. On the query port, the controller presents a block address and receives, in the same cycle, a predicted (processor, kind) pair and a flag that says whether the prediction is usable.

The history table is direct-mapped and tagged. Each of its entries owns a private pattern table of 16 entries. The pattern index is a 4-bit fold of the whole history, so the history depth can change without changing the storage per block. Each pattern entry carries a 2-bit saturating confidence counter, which stops a single unusual successor from overwriting a stable prediction. History depth, counter width, address width and table size are parameters.

Top module: `coh_msg_predictor`

## Requirements
- R1: Address bits [6:0] play no part in either port. Bits [12:7] select one of 64 history entries and bits [19:13] form the tag. Two addresses that differ only in bits [6:0] therefore refer to the same block.
- R2: An update that misses allocates the entry. A miss means the entry is invalid or its tag differs. On allocation the block stores the tag, sets the history to the arriving tuple in the newest slot with every older slot zero, and invalidates all 16 pattern entries of that set. No pattern entry is trained. Queries to the evicted block and to the new block then report predValid=0 until retraining.
- R3: A tuple is the 8-bit value {proc[3:0], kind[3:0]}. Each tuple folds to f = kind XOR rotl4(proc, 1). The pattern index is the XOR, over history slots i (slot 0 newest), of rotl4(f(slot i), i mod 4). Here rotl4 is a left rotation within 4 bits.
- R4: An update that hits and finds the indexed pattern entry invalid stores the arriving tuple in that entry, sets the counter to 0 and marks the entry valid.
- R5: An update that hits and finds a valid entry equal to the arriving tuple increments that entry's counter, saturating at 3. The stored prediction is not changed.
- R6: An update that hits and finds a valid entry that differs from the arriving tuple decrements the counter if it is above 0 and keeps the prediction. If the counter is already 0, the stored prediction is replaced by the arriving tuple and the counter stays at 0.
- R7: After the pattern step of a hitting update, the arriving tuple enters the newest history slot. Every older slot moves one place older and the oldest tuple is dropped.
- R8: The query is combinational. predValid is 1 exactly when the block hits and the pattern entry at its current history index is valid, and predProc/predType come from that entry. An update in the same cycle becomes visible only after the next rising edge.
- R9: When rst is high at a rising edge, every history and pattern entry is invalidated, so predValid is 0 for every address afterwards.
- R10: The block learns a producer-consumer stream in which the producer is processor 1 and the consumer is processor 2. The stream repeats four messages: exclusive-read request (kind 2) from 1, drop-shared acknowledgement (kind 12) from 2, shared-read request (kind 1) from 2, drop-exclusive acknowledgement (kind 13) from 1. From the sixth message on, it predicts each successor in turn. The other kinds are upgrade request 3, drop-shared request 4 and drop-exclusive request 5; each acknowledgement is its request code plus 8.
- R11: Updates to one set leave unchanged the predictions of blocks held in other sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| updValid | input | 1 | An observed message is presented this cycle |
| updAddr | input | ADDR_W (20) | Byte address of the block the message concerns |
| updProc | input | 4 | Sender processor of the observed message |
| updType | input | 4 | Kind code of the observed message |
| qryAddr | input | ADDR_W (20) | Byte address of the block to predict for |
| predValid | output | 1 | Prediction for qryAddr is usable |
| predProc | output | 4 | Predicted sender processor |
| predType | output | 4 | Predicted message kind |

## Verification
A query result is due in the same cycle as the query address, with no register in between. The effect of an update is due exactly one rising edge later. The bench drives both ports on the falling edge and samples the prediction 1 ns later. At that point it compares the prediction with a behavioural model that still holds the state from before the update. It advances the model only after the sample, which matches the one-edge latency of training and history shifting. Directed checks of the producer-consumer stream, the counter limits, conflict eviction and reset are combined with a long mixed stream on two sets and two tags.

// File: rtl/coh_pred_pkg.sv
package coh_pred_pkg;

  localparam int PROC_W = 4;
  localparam int KIND_W = 4;
  localparam int TUP_W  = PROC_W + KIND_W;
  localparam int IDX_W  = 4;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE        = 4'd0,
    KIND_SHR_REQ     = 4'd1,
    KIND_EXC_REQ     = 4'd2,
    KIND_UPG_REQ     = 4'd3,
    KIND_DROPSHR_REQ = 4'd4,
    KIND_DROPEXC_REQ = 4'd5,
    KIND_SHR_ACK     = 4'd9,
    KIND_EXC_ACK     = 4'd10,
    KIND_UPG_ACK     = 4'd11,
    KIND_DROPSHR_ACK = 4'd12,
    KIND_DROPEXC_ACK = 4'd13
  } msg_kind_e;

  typedef struct packed {
    logic [PROC_W-1:0] proc;
    logic [KIND_W-1:0] kind;
  } msg_tuple_t;

  typedef struct packed {
    logic alloc;
    logic shift;
    logic fill;
    logic bump;
    logic drop;
    logic swap;
  } tbl_strobe_t;

  function automatic logic [IDX_W-1:0] rotl4(input logic [IDX_W-1:0] x, input int n);
    logic [2*IDX_W-1:0] dbl;
    dbl = {x, x} << (n % IDX_W);
    return dbl[2*IDX_W-1:IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] foldTuple(input msg_tuple_t t);
    return t.kind ^ rotl4(t.proc, 1);
  endfunction

endpackage

// File: rtl/coh_pred_ctrl.sv
module coh_pred_ctrl
  import coh_pred_pkg::*;
#(
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              updValid,
  input  logic              updHit,
  input  logic              entValid,
  input  msg_tuple_t        entTuple,
  input  logic [FILT_W-1:0] entCtr,
  input  msg_tuple_t        updTuple,
  output tbl_strobe_t       stb
);

  localparam logic [FILT_W-1:0] CTR_MAX = '1;

  logic tupleMatch;
  logic trained;

  always_comb begin
    tupleMatch = (entTuple == updTuple);
    trained    = updValid && updHit && entValid;
    stb.alloc  = updValid && !updHit;
    stb.shift  = updValid && updHit;
    stb.fill   = updValid && updHit && !entValid;
    stb.bump   = trained && tupleMatch && (entCtr != CTR_MAX);
    stb.drop   = trained && !tupleMatch && (entCtr != '0);
    stb.swap   = trained && !tupleMatch && (entCtr == '0);
  end

  // R6: at most one pattern action per update
  a_r6_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.fill, stb.bump, stb.drop, stb.swap}));

  // R2: allocation and history shift never coincide
  a_r2_alloc_or_shift: assert property (@(posedge clk) disable iff (rst)
    stb.alloc |-> !stb.shift);

endmodule

// File: rtl/coh_pred_tables.sv
module coh_pred_tables
  import coh_pred_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SETS_LOG2  = 6,
  parameter int BLK_LOG2   = 7,
  parameter int HIST_DEPTH = 2,
  parameter int FILT_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  tbl_strobe_t       stb,
  input  logic [ADDR_W-1:0] updAddr,
  input  msg_tuple_t        updTuple,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic              updHit,
  output logic              updEntValid,
  output msg_tuple_t        updEntTuple,
  output logic [FILT_W-1:0] updEntCtr,
  output logic              qryValid,
  output msg_tuple_t        qryTuple
);

  localparam int SETS   = 1 << SETS_LOG2;
  localparam int TAG_W  = ADDR_W - SETS_LOG2 - BLK_LOG2;
  localparam int HIST_W = HIST_DEPTH * TUP_W;
  localparam int PHT_N  = 1 << IDX_W;

  logic [SETS-1:0]   mhtValid;
  logic [TAG_W-1:0]  mhtTag   [SETS];
  logic [HIST_W-1:0] mhtHist  [SETS];
  logic [PHT_N-1:0]  phtValid [SETS];
  msg_tuple_t        phtTuple [SETS][PHT_N];
  logic [FILT_W-1:0] phtCtr   [SETS][PHT_N];

  function automatic logic [IDX_W-1:0] histIndex(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      acc ^= rotl4(foldTuple(msg_tuple_t'(h[i*TUP_W +: TUP_W])), i);
    end
    return acc;
  endfunction

  logic [SETS_LOG2-1:0] uSet, qSet;
  logic [TAG_W-1:0]     uTag, qTag;
  logic [IDX_W-1:0]     uIdx, qIdx;
  logic [HIST_W-1:0]    histShifted, histAlloc;
  logic                 qHit;
  logic                 unusedOffsets;

  assign unusedOffsets = ^{updAddr[BLK_LOG2-1:0], qryAddr[BLK_LOG2-1:0]};

  always_comb begin
    uSet = updAddr[BLK_LOG2 +: SETS_LOG2];
    uTag = updAddr[ADDR_W-1 -: TAG_W];
    qSet = qryAddr[BLK_LOG2 +: SETS_LOG2];
    qTag = qryAddr[ADDR_W-1 -: TAG_W];
    uIdx = histIndex(mhtHist[uSet]);
    qIdx = histIndex(mhtHist[qSet]);

    updHit      = mhtValid[uSet] && (mhtTag[uSet] == uTag);
    updEntValid = phtValid[uSet][uIdx];
    updEntTuple = phtTuple[uSet][uIdx];
    updEntCtr   = phtCtr[uSet][uIdx];

    qHit     = mhtValid[qSet] && (mhtTag[qSet] == qTag);
    qryValid = qHit && phtValid[qSet][qIdx];
    qryTuple = phtTuple[qSet][qIdx];

    histShifted = mhtHist[uSet] << TUP_W;
    histShifted[TUP_W-1:0] = updTuple;
    histAlloc = '0;
    histAlloc[TUP_W-1:0] = updTuple;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mhtValid <= '0;
      for (int s = 0; s < SETS; s++) phtValid[s] <= '0;
    end else begin
      if (stb.alloc) begin
        mhtValid[uSet] <= 1'b1;
        mhtTag[uSet]   <= uTag;
        mhtHist[uSet]  <= histAlloc;
        phtValid[uSet] <= '0;
      end
      if (stb.shift) mhtHist[uSet] <= histShifted;
      if (stb.fill || stb.swap) begin
        phtValid[uSet][uIdx] <= 1'b1;
        phtTuple[uSet][uIdx] <= updTuple;
        phtCtr[uSet][uIdx]   <= '0;
      end
      if (stb.bump) phtCtr[uSet][uIdx] <= updEntCtr + 1'b1;
      if (stb.drop) phtCtr[uSet][uIdx] <= updEntCtr - 1'b1;
    end
  end

  // Snapshot of the last update's lookup, used by the checks below
  logic [SETS_LOG2-1:0] prevSet;
  logic [IDX_W-1:0]     prevIdx;
  msg_tuple_t           prevTuple, prevEntTuple;
  logic [FILT_W-1:0]    prevEntCtr;
  logic [TAG_W-1:0]     prevTag;

  always_ff @(posedge clk) begin
    prevSet      <= uSet;
    prevIdx      <= uIdx;
    prevTuple    <= updTuple;
    prevEntTuple <= updEntTuple;
    prevEntCtr   <= updEntCtr;
    prevTag      <= uTag;
  end

  a_r2_alloc_clears: assert property (@(posedge clk) disable iff (rst)
    stb.alloc |=> (phtValid[prevSet] == '0) && mhtValid[prevSet] && (mhtTag[prevSet] == prevTag));

  a_r4_fill_installs: assert property (@(posedge clk) disable iff (rst)
    (stb.fill || stb.swap) |=> phtValid[prevSet][prevIdx] &&
      (phtTuple[prevSet][prevIdx] == prevTuple) && (phtCtr[prevSet][prevIdx] == '0));

  a_r5_bump_step: assert property (@(posedge clk) disable iff (rst)
    stb.bump |=> (phtCtr[prevSet][prevIdx] == prevEntCtr + 1'b1) &&
      (phtTuple[prevSet][prevIdx] == prevEntTuple));

  a_r6_drop_keeps: assert property (@(posedge clk) disable iff (rst)
    stb.drop |=> (phtTuple[prevSet][prevIdx] == prevEntTuple) &&
      (phtCtr[prevSet][prevIdx] == prevEntCtr - 1'b1));

  a_r7_newest_slot: assert property (@(posedge clk) disable iff (rst)
    stb.shift |=> (mhtHist[prevSet][TUP_W-1:0] == prevTuple));

  a_r9_reset_empties: assert property (@(posedge clk)
    rst |=> (mhtValid == '0) && !qryValid);

endmodule

// File: rtl/coh_msg_predictor.sv
module coh_msg_predictor
  import coh_pred_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SETS_LOG2  = 6,
  parameter int BLK_LOG2   = 7,
  parameter int HIST_DEPTH = 2,
  parameter int FILT_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [3:0]        updProc,
  input  logic [3:0]        updType,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic              predValid,
  output logic [3:0]        predProc,
  output logic [3:0]        predType
);

  msg_tuple_t        updTuple, entTuple, qryTuple;
  tbl_strobe_t       stb;
  logic              updHit, entValid;
  logic [FILT_W-1:0] entCtr;

  assign updTuple = '{proc: updProc, kind: updType};
  assign predProc = qryTuple.proc;
  assign predType = qryTuple.kind;

  coh_pred_ctrl #(.FILT_W(FILT_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .updValid (updValid),
    .updHit   (updHit),
    .entValid (entValid),
    .entTuple (entTuple),
    .entCtr   (entCtr),
    .updTuple (updTuple),
    .stb      (stb)
  );

  coh_pred_tables #(
    .ADDR_W     (ADDR_W),
    .SETS_LOG2  (SETS_LOG2),
    .BLK_LOG2   (BLK_LOG2),
    .HIST_DEPTH (HIST_DEPTH),
    .FILT_W     (FILT_W)
  ) i_tables (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .updAddr     (updAddr),
    .updTuple    (updTuple),
    .qryAddr     (qryAddr),
    .updHit      (updHit),
    .updEntValid (entValid),
    .updEntTuple (entTuple),
    .updEntCtr   (entCtr),
    .qryValid    (predValid),
    .qryTuple    (qryTuple)
  );

endmodule

// File: tb/test_coh_msg_predictor.sv
`timescale 1ns/1ps
module test_coh_msg_predictor;

  localparam int AW    = 20;
  localparam int SETS  = 64;
  localparam int PN    = 16;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, updValid;
  logic [AW-1:0] updAddr, qryAddr;
  logic [3:0]    updProc, updType;
  logic          predValid;
  logic [3:0]    predProc, predType;

  coh_msg_predictor i_coh_msg_predictor (
    .clk(clk), .rst(rst), .updValid(updValid), .updAddr(updAddr),
    .updProc(updProc), .updType(updType), .qryAddr(qryAddr),
    .predValid(predValid), .predProc(predProc), .predType(predType)
  );

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  // Behavioural reference state
  bit mVal [SETS];
  int mTag [SETS];
  int mHist[SETS][DEPTH];
  bit pVal [SETS][PN];
  int pTup [SETS][PN];
  int pCtr [SETS][PN];

  function automatic int rot4(int x, int n);
    n = n % 4;
    return ((x << n) | (x >> (4 - n))) & 15;
  endfunction

  function automatic int foldOf(int t);
    return (t & 15) ^ rot4((t >> 4) & 15, 1);
  endfunction

  function automatic int idxOf(int s);
    int r = 0;
    for (int i = 0; i < DEPTH; i++) r ^= rot4(foldOf(mHist[s][i]), i);
    return r;
  endfunction

  function automatic void modelClear();
    for (int s = 0; s < SETS; s++) begin
      mVal[s] = 0;
      for (int i = 0; i < PN; i++) pVal[s][i] = 0;
    end
  endfunction

  function automatic void modelPred(int a, output int v, output int t);
    int s = (a >> 7) & 63;
    int g = a >> 13;
    v = 0; t = 0;
    if (mVal[s] && mTag[s] == g) begin
      int i = idxOf(s);
      v = pVal[s][i];
      t = pTup[s][i];
    end
  endfunction

  function automatic void modelUpd(int a, int t);
    int s = (a >> 7) & 63;
    int g = a >> 13;
    if (!mVal[s] || mTag[s] != g) begin
      mVal[s] = 1; mTag[s] = g;
      for (int k = 0; k < DEPTH; k++) mHist[s][k] = 0;
      mHist[s][0] = t;
      for (int i = 0; i < PN; i++) pVal[s][i] = 0;
    end else begin
      int i = idxOf(s);
      if (!pVal[s][i]) begin
        pVal[s][i] = 1; pTup[s][i] = t; pCtr[s][i] = 0;
      end else if (pTup[s][i] == t) begin
        if (pCtr[s][i] < 3) pCtr[s][i]++;
      end else if (pCtr[s][i] == 0) begin
        pTup[s][i] = t;
      end else begin
        pCtr[s][i]--;
      end
      for (int k = DEPTH - 1; k > 0; k--) mHist[s][k] = mHist[s][k-1];
      mHist[s][0] = t;
    end
  endfunction

  task automatic compare(string req, int expV, int expT);
    int act, exp;
    act = predValid ? (256 | int'({predProc, predType})) : 0;
    exp = expV ? (256 | expT) : 0;
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at falling edge, compare pre-update prediction, then advance model
  task automatic step(bit uv, int ua, int up, int ut, int qa, string req);
    int v, t;
    updValid = uv; updAddr = AW'(ua); updProc = 4'(up); updType = 4'(ut);
    qryAddr = AW'(qa);
    #1;
    modelPred(qa, v, t);
    compare(req, v, t);
    if (uv) modelUpd(ua, up * 16 + ut);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic peek(int qa, int expV, int expT, string req);
    updValid = 0; qryAddr = AW'(qa);
    #1;
    compare(req, expV, expT);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1; updValid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    modelClear();
  endtask

  // Tuples as proc*16+kind
  localparam int PA = 1 * 16 + 2;   // exclusive-read request from producer
  localparam int PB = 2 * 16 + 12;  // drop-shared ack from consumer
  localparam int PC = 2 * 16 + 1;   // shared-read request from consumer
  localparam int PD = 1 * 16 + 13;  // drop-exclusive ack from producer
  localparam int TT = 3 * 16 + 1;
  localparam int UU = 5 * 16 + 2;

  task automatic stepT(int a, int t, string req);
    step(1, a, t >> 4, t & 15, a, req);
  endtask

  initial begin
    int pcAddr, cfAddr, fAddr;
    pcAddr = 'h01080;
    cfAddr = pcAddr ^ 'h02000;
    fAddr  = 'h00400;
    updValid = 0; updAddr = '0; updProc = '0; updType = '0; qryAddr = '0;
    doReset();

    // R9: nothing predicted after reset
    peek(pcAddr, 0, 0, "R9");
    peek(fAddr, 0, 0, "R9");

    // R10: producer-consumer stream
    stepT(pcAddr, PA, "R10");
    stepT(pcAddr, PB, "R10");
    stepT(pcAddr, PC, "R10");
    stepT(pcAddr, PD, "R10");
    stepT(pcAddr, PA, "R10");
    stepT(pcAddr, PB, "R10");
    peek(pcAddr, 1, PC, "R4");
    peek(pcAddr | 'h7F, 1, PC, "R1");
    peek(pcAddr | 'h35, 1, PC, "R1");
    stepT(pcAddr, PC, "R8");
    peek(pcAddr, 1, PD, "R10");
    stepT(pcAddr, PD, "R3");
    peek(pcAddr, 1, PA, "R10");
    stepT(pcAddr, PA, "R3");
    peek(pcAddr, 1, PB, "R10");

    // R2: conflicting tag in the same set evicts
    stepT(cfAddr, 3 * 16 + 1, "R2");
    peek(pcAddr, 0, 0, "R2");
    peek(cfAddr, 0, 0, "R2");

    // R5 / R6: counter saturation and replacement
    for (int n = 0; n < 7; n++) stepT(fAddr, TT, "R7");
    peek(fAddr, 1, TT, "R5");
    for (int r = 0; r < 3; r++) begin
      stepT(fAddr, UU, "R6");
      stepT(fAddr, TT, "R7");
      stepT(fAddr, TT, "R7");
      peek(fAddr, 1, TT, r < 2 ? "R5" : "R6");
    end
    stepT(fAddr, UU, "R6");
    stepT(fAddr, TT, "R7");
    stepT(fAddr, TT, "R7");
    peek(fAddr, 1, UU, "R6");

    // R11: other sets untouched
    stepT(cfAddr, PA, "R11");
    stepT(cfAddr ^ 'h04000, PB, "R11");
    stepT(pcAddr, PC, "R11");
    peek(fAddr, 1, UU, "R11");

    // R9: reset again clears learnt state
    doReset();
    peek(fAddr, 0, 0, "R9");
    peek(pcAddr, 0, 0, "R9");

    // Mixed stream over two sets and two tags
    for (int n = 0; n < 3000; n++) begin
      int kinds[4] = '{2, 12, 1, 13};
      int ua, qa;
      ua = ($urandom_range(0, 1) << 13) | ($urandom_range(5, 6) << 7) | $urandom_range(0, 127);
      qa = ($urandom_range(0, 1) << 13) | ($urandom_range(5, 6) << 7) | $urandom_range(0, 127);
      step($urandom_range(0, 3) != 0, ua, $urandom_range(0, 3), kinds[$urandom_range(0, 3)], qa, "R3");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule